// File: doc/BRIEF.md
# Two-by-Two BPSK Maximum-Likelihood Detector

This block recovers two BPSK symbols sent over a link with two transmit and two receive antennas. The received samples are modelled as y = Hx + n, with H a complex 2x2 channel. Each cycle the block takes the real and imaginary parts of both received samples and of all four channel coefficients, as signed fixed-point words. It then evaluates every one of the four candidate symbol pairs (s1, s2), with each symbol in {+1, -1}.

For each candidate, four identical per-axis metric units form the residual y - h_a*s1 - h_b*s2 on one real or imaginary axis of one receiver. Because the symbols are only +1 or -1, each product is the coefficient either passed through or negated, so no multiplier is built. The four absolute residuals are added into one candidate metric. A shared minimum tree then picks the smallest of the four metrics. The block returns the detected bit pair and the winning metric two cycles after the input, with a valid flag that follows the input valid.

Top module: `mld_2x2_bpsk_det`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and det_s1, det_s2 and min_metric read 0 until the first valid input has passed through.
- R2: out_valid is high exactly two clock cycles after each cycle in which in_valid is high, and low otherwise. Every valid input produces exactly one output.
- R3: min_metric equals the minimum, over the four candidates, of |y1re - h11re*s1 - h12re*s2| + |y1im - h11im*s1 - h12im*s2| + |y2re - h21re*s1 - h22re*s2| + |y2im - h21im*s1 - h22im*s2|. It is computed in DW+3 unsigned bits, so it is exact for every input at the extremes of the signed DW-bit range.
- R4: det_s1 and det_s2 give the symbols of the winning candidate, with data bit 0 meaning +1 and data bit 1 meaning -1. The candidate index is {det_s1, det_s2}, so index 0 = (+1,+1), 1 = (+1,-1), 2 = (-1,+1) and 3 = (-1,-1).
- R5: When several candidates share the smallest metric, the one with the lowest index wins.
- R6: In a cycle where in_valid is low, the data inputs are ignored. The outputs det_s1, det_s2 and min_metric hold their last values whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | The sample and channel inputs are valid this cycle |
| y1_re | input | DW | Receiver 1 sample, real part (signed) |
| y1_im | input | DW | Receiver 1 sample, imaginary part (signed) |
| y2_re | input | DW | Receiver 2 sample, real part (signed) |
| y2_im | input | DW | Receiver 2 sample, imaginary part (signed) |
| h11_re | input | DW | Channel, transmitter 1 to receiver 1, real part (signed) |
| h11_im | input | DW | Channel, transmitter 1 to receiver 1, imaginary part (signed) |
| h12_re | input | DW | Channel, transmitter 2 to receiver 1, real part (signed) |
| h12_im | input | DW | Channel, transmitter 2 to receiver 1, imaginary part (signed) |
| h21_re | input | DW | Channel, transmitter 1 to receiver 2, real part (signed) |
| h21_im | input | DW | Channel, transmitter 1 to receiver 2, imaginary part (signed) |
| h22_re | input | DW | Channel, transmitter 2 to receiver 2, real part (signed) |
| h22_im | input | DW | Channel, transmitter 2 to receiver 2, imaginary part (signed) |
| out_valid | output | 1 | The detection result is valid |
| det_s1 | output | 1 | Detected bit for transmitter 1 (0 means +1) |
| det_s2 | output | 1 | Detected bit for transmitter 2 (0 means +1) |
| min_metric | output | DW+3 | Metric of the winning candidate (unsigned) |

## Verification
The bench builds the block with DW = 8. At that width the most negative input, -128, and the most positive, 127, are easy to drive on every sample and coefficient at once. This reaches the case where negation needs the extra residual bit and the case where the candidate sums come close to the widened metric range. The small width also makes exact ties between candidates simple to set up, so the lowest-index rule is checked for several winning indices, alongside a long run of pseudo-random vectors compared against an integer model.

// File: rtl/mld_pkg.sv
package mld_pkg;

  localparam int NCAND = 4;

  // Candidate index is {bit_s1, bit_s2}; bit 1 means symbol -1.
  function automatic logic cand_neg_s1(input int unsigned idx);
    return idx[1];
  endfunction

  function automatic logic cand_neg_s2(input int unsigned idx);
    return idx[0];
  endfunction

endpackage

// File: rtl/mld_rst_sync.sv
module mld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/mld_axis_metric.sv
module mld_axis_metric
  import mld_pkg::*;
#(
  parameter int DW = 12,
  localparam int AW = DW + 2
) (
  input  logic signed [DW-1:0]       y,
  input  logic signed [DW-1:0]       ha,
  input  logic signed [DW-1:0]       hb,
  output logic [NCAND-1:0][AW-1:0]   mag
);

  logic signed [AW-1:0] y_x;
  logic signed [AW-1:0] ha_x;
  logic signed [AW-1:0] hb_x;

  always_comb begin
    y_x  = AW'(y);
    ha_x = AW'(ha);
    hb_x = AW'(hb);
  end

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    logic signed [AW-1:0] term_a;
    logic signed [AW-1:0] term_b;
    logic signed [AW-1:0] resid;

    always_comb begin
      term_a = cand_neg_s1(k) ? -ha_x : ha_x;
      term_b = cand_neg_s2(k) ? -hb_x : hb_x;
      resid  = y_x - term_a - term_b;
      mag[k] = resid[AW-1] ? AW'(-resid) : AW'(resid);
    end
  end

endmodule

// File: rtl/mld_min_tree.sv
module mld_min_tree
  import mld_pkg::*;
#(
  parameter int MW = 15
) (
  input  logic [NCAND-1:0][MW-1:0] metric,
  output logic [1:0]               win_idx,
  output logic [MW-1:0]            win_val
);

  logic [1:0][MW-1:0] pair_val;
  logic [1:0]         pair_sel;

  // Level 1: the right entry wins only when strictly smaller.
  for (genvar p = 0; p < 2; p++) begin : g_pair
    always_comb begin
      pair_sel[p] = metric[2*p+1] < metric[2*p];
      pair_val[p] = pair_sel[p] ? metric[2*p+1] : metric[2*p];
    end
  end

  logic hi_wins;

  always_comb begin
    hi_wins = pair_val[1] < pair_val[0];
    win_val = hi_wins ? pair_val[1] : pair_val[0];
    win_idx = hi_wins ? {1'b1, pair_sel[1]} : {1'b0, pair_sel[0]};
  end

endmodule

// File: rtl/mld_2x2_bpsk_det.sv
module mld_2x2_bpsk_det
  import mld_pkg::*;
#(
  parameter int DW = 12,
  localparam int AW = DW + 2,
  localparam int MW = DW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] y1_re,
  input  logic signed [DW-1:0] y1_im,
  input  logic signed [DW-1:0] y2_re,
  input  logic signed [DW-1:0] y2_im,
  input  logic signed [DW-1:0] h11_re,
  input  logic signed [DW-1:0] h11_im,
  input  logic signed [DW-1:0] h12_re,
  input  logic signed [DW-1:0] h12_im,
  input  logic signed [DW-1:0] h21_re,
  input  logic signed [DW-1:0] h21_im,
  input  logic signed [DW-1:0] h22_re,
  input  logic signed [DW-1:0] h22_im,
  output logic                 out_valid,
  output logic                 det_s1,
  output logic                 det_s2,
  output logic [MW-1:0]        min_metric
);

  localparam int NAX = 4;

  logic rst_sync_n;

  mld_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Axis order: rx1 real, rx1 imag, rx2 real, rx2 imag.
  logic [NAX-1:0][DW-1:0] ax_y;
  logic [NAX-1:0][DW-1:0] ax_ha;
  logic [NAX-1:0][DW-1:0] ax_hb;

  always_comb begin
    ax_y  = {y2_im,  y2_re,  y1_im,  y1_re};
    ax_ha = {h21_im, h21_re, h11_im, h11_re};
    ax_hb = {h22_im, h22_re, h12_im, h12_re};
  end

  logic [NAX-1:0][NCAND-1:0][AW-1:0] ax_mag;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    mld_axis_metric #(.DW(DW)) u_axis (
      .y   (ax_y[a]),
      .ha  (ax_ha[a]),
      .hb  (ax_hb[a]),
      .mag (ax_mag[a])
    );
  end

  logic [NCAND-1:0][MW-1:0] metric_d;

  always_comb begin
    for (int k = 0; k < NCAND; k++) begin
      metric_d[k] = '0;
      for (int a = 0; a < NAX; a++) begin
        metric_d[k] = metric_d[k] + MW'(ax_mag[a][k]);
      end
    end
  end

  // Stage 1: candidate metrics
  logic [NCAND-1:0][MW-1:0] metric_q;
  logic [NCAND-1:0][MW-1:0] metric_nxt;
  logic                     v1_q;
  logic                     v1_nxt;
  logic                     s1_en;

  always_comb begin
    s1_en      = in_valid;
    v1_nxt     = in_valid;
    metric_nxt = s1_en ? metric_d : metric_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q     <= 1'b0;
      metric_q <= '0;
    end else begin
      v1_q     <= v1_nxt;
      metric_q <= metric_nxt;
    end
  end

  logic [1:0]    win_idx;
  logic [MW-1:0] win_val;

  mld_min_tree #(.MW(MW)) u_min (
    .metric  (metric_q),
    .win_idx (win_idx),
    .win_val (win_val)
  );

  // Stage 2: selected result
  logic [1:0]    idx_q;
  logic [1:0]    idx_nxt;
  logic [MW-1:0] val_q;
  logic [MW-1:0] val_nxt;
  logic          v2_q;
  logic          v2_nxt;
  logic          s2_en;

  always_comb begin
    s2_en   = v1_q;
    v2_nxt  = v1_q;
    idx_nxt = s2_en ? win_idx : idx_q;
    val_nxt = s2_en ? win_val : val_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v2_q  <= 1'b0;
      idx_q <= '0;
      val_q <= '0;
    end else begin
      v2_q  <= v2_nxt;
      idx_q <= idx_nxt;
      val_q <= val_nxt;
    end
  end

  assign out_valid  = v2_q;
  assign det_s1     = idx_q[1];
  assign det_s2     = idx_q[0];
  assign min_metric = val_q;

endmodule

// File: rtl/mld_det_checker.sv
module mld_det_checker #(
  parameter int DW = 12,
  localparam int MW = DW + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [3:0][MW-1:0]   metrics,
  input logic                 out_valid,
  input logic                 det_s1,
  input logic                 det_s2,
  input logic [MW-1:0]        min_metric
);

  localparam logic [MW-1:0] MAX_SUM = MW'(3 * (1 << (DW + 1)));

  logic [3:0][MW-1:0] m_prev;
  logic [1:0]         idx;

  always_ff @(posedge clk) begin
    m_prev <= metrics;
  end

  assign idx = {det_s1, det_s2};

  // R2: two-cycle latency of the valid flag
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  // R3: winner is no larger than any candidate
  assert_min_le_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (min_metric <= m_prev[0] && min_metric <= m_prev[1] &&
                   min_metric <= m_prev[2] && min_metric <= m_prev[3]));

  // R3: sums stay inside the widened range
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (metrics[0] <= MAX_SUM && metrics[1] <= MAX_SUM &&
                  metrics[2] <= MAX_SUM && metrics[3] <= MAX_SUM));

  // R4: reported bits point at the reported metric
  assert_metric_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> min_metric == m_prev[idx]);

  // R5: lower-index candidates lose only when strictly larger
  assert_tie_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx != 2'd0) |-> m_prev[0] > min_metric);

  assert_tie_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx[1]) |-> m_prev[1] > min_metric);

  assert_tie_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx == 2'd3) |-> m_prev[2] > min_metric);

  // R6: outputs hold while no result is presented
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(min_metric) && $stable(det_s1) && $stable(det_s2)));

endmodule

bind mld_2x2_bpsk_det mld_det_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .metrics    (metric_q),
  .out_valid  (out_valid),
  .det_s1     (det_s1),
  .det_s2     (det_s2),
  .min_metric (min_metric)
);

// File: tb/mld_2x2_bpsk_det_tb.sv
`timescale 1ns/1ps
module mld_2x2_bpsk_det_tb;

  localparam int DW = 8;
  localparam int MW = DW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] y1_re = '0, y1_im = '0, y2_re = '0, y2_im = '0;
  logic signed [DW-1:0] h11_re = '0, h11_im = '0, h12_re = '0, h12_im = '0;
  logic signed [DW-1:0] h21_re = '0, h21_im = '0, h22_re = '0, h22_im = '0;
  logic          out_valid;
  logic          det_s1;
  logic          det_s2;
  logic [MW-1:0] min_metric;

  always #4 clk = ~clk;

  mld_2x2_bpsk_det #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .y1_re(y1_re), .y1_im(y1_im), .y2_re(y2_re), .y2_im(y2_im),
    .h11_re(h11_re), .h11_im(h11_im), .h12_re(h12_re), .h12_im(h12_im),
    .h21_re(h21_re), .h21_im(h21_im), .h22_re(h22_re), .h22_im(h22_im),
    .out_valid(out_valid), .det_s1(det_s1), .det_s2(det_s2),
    .min_metric(min_metric)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int m_checks = 0;
  int m_fails  = 0;
  int exp_q[$];
  int last_exp = 0;
  int lcg = 12345;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // v order: y1r y1i y2r y2i h11r h11i h12r h12i h21r h21i h22r h22i
  function automatic int model(input int v[12]);
    int best;
    int bidx;
    best = -1;
    bidx = 0;
    for (int k = 0; k < 4; k++) begin
      int s1;
      int s2;
      int m;
      s1 = (k >= 2) ? -1 : 1;
      s2 = (k % 2 == 1) ? -1 : 1;
      m = iabs(v[0] - v[4]*s1 - v[6]*s2) + iabs(v[1] - v[5]*s1 - v[7]*s2)
        + iabs(v[2] - v[8]*s1 - v[10]*s2) + iabs(v[3] - v[9]*s1 - v[11]*s2);
      if (best < 0 || m < best) begin
        best = m;
        bidx = k;
      end
    end
    return best * 4 + bidx;
  endfunction

  task automatic put(input int v[12]);
    y1_re  = DW'(v[0]);  y1_im  = DW'(v[1]);
    y2_re  = DW'(v[2]);  y2_im  = DW'(v[3]);
    h11_re = DW'(v[4]);  h11_im = DW'(v[5]);
    h12_re = DW'(v[6]);  h12_im = DW'(v[7]);
    h21_re = DW'(v[8]);  h21_im = DW'(v[9]);
    h22_re = DW'(v[10]); h22_im = DW'(v[11]);
  endtask

  task automatic send(input int v[12]);
    @(negedge clk);
    put(v);
    in_valid = 1'b1;
    exp_q.push_back(model(v));
  endtask

  task automatic idle(input int v[12]);
    @(negedge clk);
    put(v);
    in_valid = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 16) & 255) - 128;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      m_checks++;
      if (exp_q.size() == 0) begin
        m_fails++;
        $display("[TB] FAIL R2 actual=unexpected output expected=none");
      end else begin
        int e;
        e = exp_q.pop_front();
        last_exp = e;
        if (int'(min_metric) != e / 4) begin
          m_fails++;
          $display("[TB] FAIL R3 metric actual=%0d expected=%0d", min_metric, e / 4);
        end
        m_checks++;
        if (int'({det_s1, det_s2}) != e % 4) begin
          m_fails++;
          $display("[TB] FAIL R4/R5 index actual=%0d expected=%0d",
                   {det_s1, det_s2}, e % 4);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    $display("[TB] FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks + m_checks + 1,
             n_fails + m_fails + 1);
    $finish;
  end

  initial begin
    int z[12];
    int v[12];
    foreach (z[i]) z[i] = 0;

    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 metric after reset", min_metric, 0);
    check("R1 bits after reset", {det_s1, det_s2}, 0);

    // R2: latency of a single item; also R5 all-zero tie -> index 0
    send(z);
    idle(z);
    check("R2 not yet valid", out_valid, 0);
    idle(z);
    check("R2 valid after two cycles", out_valid, 1);
    idle(z);
    check("R2 single pulse", out_valid, 0);

    // R4: each candidate wins with a clean identity channel
    for (int k = 0; k < 4; k++) begin
      int s1;
      int s2;
      s1 = (k >= 2) ? -1 : 1;
      s2 = (k % 2 == 1) ? -1 : 1;
      foreach (v[i]) v[i] = 0;
      v[4] = 40; v[10] = 40;            // h11 = h22 = 40
      v[0] = 40 * s1; v[2] = 40 * s2;
      send(v);
    end
    repeat (3) idle(z);

    // R3: extreme values
    foreach (v[i]) v[i] = (i < 4) ? -128 : 127;
    send(v);                            // expect 504, idx 3
    check("R3 model extreme A", model(v), 504 * 4 + 3);
    foreach (v[i]) v[i] = (i < 4) ? 127 : -128;
    send(v);                            // 508, tie 1/2 -> idx 1 (R5)
    check("R5 model tie extreme B", model(v), 508 * 4 + 1);
    foreach (v[i]) v[i] = (i < 4) ? -128 : 0;
    send(v);                            // all 512, tie -> idx 0
    // R5: tie between candidates 2 and 3 only (h12 = 0 everywhere)
    foreach (v[i]) v[i] = 0;
    v[0] = -50; v[4] = 50;
    send(v);
    repeat (3) idle(z);

    // R6: garbage on data inputs while in_valid is low
    for (int c = 0; c < 6; c++) begin
      foreach (v[i]) v[i] = rnd();
      idle(v);
      check("R6 no output while idle", out_valid, 0);
      check("R6 metric held", min_metric, last_exp / 4);
      check("R6 bits held", {det_s1, det_s2}, last_exp % 4);
    end

    // R3/R4: pseudo-random burst, with gaps
    for (int n = 0; n < 300; n++) begin
      foreach (v[i]) v[i] = rnd();
      if (n % 7 == 3) idle(v);
      else send(v);
    end
    repeat (4) idle(z);
    check("R2 all outputs delivered", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks + m_checks,
             n_fails + m_fails);
    $finish;
  end

endmodule